// File: doc/BRIEF.md
# Flash configuration register unit

This block keeps the mode and configuration state of a serial NOR flash device. It sits beside the command sequencer, which does the serial shifting and owns the memory array. The sequencer hands over each opcode as a one-cycle strobe, then the data bytes of a write command, and it pulls read bytes one at a time. The block answers with register read data and drives the mode outputs the sequencer needs to frame later accesses: four-byte addressing, the dummy clock count and the upper address segment.

The state held here is a 16-bit non-volatile configuration word, an 8-bit volatile configuration register, an 8-bit enhanced volatile configuration register, an 8-bit extended (segment) address register, the four-byte address flag and the write-enable latch. A hardware reset, or a software reset issued in two steps, rebuilds every volatile register from fields of the non-volatile word. The non-volatile word is reloaded only by hardware reset.

Top module: `flash_cfg_regs`

## Requirements
- R1: After hardware reset the non-volatile word is 0x8FFF, the write-enable latch is clear, and the volatile state is rebuilt from that word as R2 to R4 describe (volatile 0x83, enhanced 0xDF, four-byte mode off, segment 0 for the default word).
- R2: On any reset the volatile register becomes: bits 1:0 set, bit 2 clear, bit 3 set unless non-volatile bits 11:9 are all ones, bits 7:4 equal to non-volatile bits 15:12. Output `dummy_clks` always shows volatile bits 7:4.
- R3: On any reset the enhanced register becomes: bits 2:0 = 7, bits 3 and 4 set, bit 5 clear, bit 6 = non-volatile bit 2, bit 7 = non-volatile bit 3.
- R4: On any reset four-byte mode is on exactly when non-volatile bit 0 is 0, and the segment register is (device bytes / 16 MiB) − 1 (3 for the default 64 MiB) when non-volatile bit 1 is 0, else 0.
- R5: Opcode 0xB7 turns four-byte mode on and 0xE9 turns it off, with no write enable needed; `addr_4b` follows one cycle after the strobe.
- R6: Opcode 0xC8 reads the segment register as one byte; opcode 0xC5 followed by one data byte writes it, but only if the write-enable latch was set when 0xC5 arrived; otherwise the byte is ignored and the register keeps its value.
- R7: Opcode 0xB1 followed by two bytes, low byte first, writes the non-volatile word when write enable was set at the opcode; opcode 0xB5 reads it back as two bytes, low byte first. The word keeps its value across a software reset.
- R8: Opcodes 0x81 / 0x85 write and read the volatile register and 0x61 / 0x65 the enhanced register, one byte each; the writes take effect only when write enable was set at the opcode.
- R9: Opcode 0x70 returns a flag byte with bit 7 = 1 (ready), bit 0 = four-byte mode and bits 6:1 = 0, repeated for every further byte pulled in the same transaction.
- R10: Opcode 0x66 arms the software reset and every other opcode disarms it; opcode 0x99 performs the R2 to R4 rebuild and clears write enable only when the command directly before it was 0x66, and otherwise changes nothing.
- R11: Opcode 0x06 sets and 0x04 clears the write-enable latch, shown on `wren`; a single-byte or two-byte register read returns 0x00 for any byte pulled past its last byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| cmd_vld | input | 1 | One-cycle strobe: a new opcode starts a transaction |
| cmd_op | input | 8 | Opcode, valid with cmd_vld |
| wr_vld | input | 1 | One-cycle strobe: a data byte for the current write command |
| wr_byte | input | 8 | Data byte, valid with wr_vld |
| rd_req | input | 1 | Advance to the next read byte |
| cs_end | input | 1 | Transaction ends (chip select released) |
| rd_data | output | 8 | Current read byte of the transaction |
| addr_4b | output | 1 | Four-byte address mode |
| dummy_clks | output | 4 | Dummy clock count for fast reads |
| seg_addr | output | 8 | Extended address segment |
| wren | output | 1 | Write-enable latch |

## Verification
The assertions take for granted that the sequencer presents at most one of cmd_vld, wr_vld, rd_req and cs_end in a cycle and that data bytes only arrive after a write opcode in the same transaction. The bench drives each strobe from its own task, one cycle wide and never overlapping, and always closes a transaction with cs_end before the next opcode. Random opcodes, write bytes and read lengths are mixed with directed sequences such as a reset opcode with no arming, an arming cancelled by an intervening command, and writes attempted without write enable.

// File: rtl/flash_cfg_regs.sv
module flash_cfg_regs #(
  parameter int          DEV_ADDR_BITS = 26,
  parameter logic [15:0] NV_RESET      = 16'h8FFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_vld,
  input  logic [7:0] cmd_op,
  input  logic       wr_vld,
  input  logic [7:0] wr_byte,
  input  logic       rd_req,
  input  logic       cs_end,
  output logic [7:0] rd_data,
  output logic       addr_4b,
  output logic [3:0] dummy_clks,
  output logic [7:0] seg_addr,
  output logic       wren
);

  localparam logic [7:0] SEG_TOP = (DEV_ADDR_BITS > 24) ? 8'((1 << (DEV_ADDR_BITS - 24)) - 1) : 8'd0;

  localparam logic [7:0] OP_WREN   = 8'h06;
  localparam logic [7:0] OP_WRDI   = 8'h04;
  localparam logic [7:0] OP_A4_ON  = 8'hB7;
  localparam logic [7:0] OP_A4_OFF = 8'hE9;
  localparam logic [7:0] OP_SEG_RD = 8'hC8;
  localparam logic [7:0] OP_SEG_WR = 8'hC5;
  localparam logic [7:0] OP_NV_RD  = 8'hB5;
  localparam logic [7:0] OP_NV_WR  = 8'hB1;
  localparam logic [7:0] OP_VC_RD  = 8'h85;
  localparam logic [7:0] OP_VC_WR  = 8'h81;
  localparam logic [7:0] OP_EV_RD  = 8'h65;
  localparam logic [7:0] OP_EV_WR  = 8'h61;
  localparam logic [7:0] OP_FLAG   = 8'h70;
  localparam logic [7:0] OP_RST_EN = 8'h66;
  localparam logic [7:0] OP_RST    = 8'h99;

  typedef enum logic [1:0] {S_IDLE, S_COLL, S_READ} st_t;
  typedef enum logic [1:0] {T_SEG, T_NV, T_VC, T_EV} tgt_t;

  function automatic logic [7:0] vc_from(input logic [15:0] nv);
    return {nv[15:12], ~&nv[11:9], 1'b0, 2'b11};
  endfunction

  function automatic logic [7:0] ev_from(input logic [15:0] nv);
    return {nv[3], nv[2], 1'b0, 2'b11, 3'b111};
  endfunction

  function automatic logic [7:0] seg_from(input logic [15:0] nv);
    return nv[1] ? 8'd0 : SEG_TOP;
  endfunction

  logic [15:0] nv_q;
  logic [7:0]  vc_q, ev_q, seg_q;
  logic        a4_q, wren_q, armed_q;
  st_t         st_q;
  tgt_t        tgt_q;
  logic        two_q, got_q;
  logic [7:0]  lo_q, rb0_q, rb1_q;
  logic [1:0]  rlen_q, rpos_q;
  logic        rloop_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nv_q    <= NV_RESET;
      vc_q    <= vc_from(NV_RESET);
      ev_q    <= ev_from(NV_RESET);
      seg_q   <= seg_from(NV_RESET);
      a4_q    <= ~NV_RESET[0];
      wren_q  <= 1'b0;
      armed_q <= 1'b0;
      st_q    <= S_IDLE;
      tgt_q   <= T_SEG;
      two_q   <= 1'b0;
      got_q   <= 1'b0;
      lo_q    <= '0;
      rb0_q   <= '0;
      rb1_q   <= '0;
      rlen_q  <= '0;
      rpos_q  <= '0;
      rloop_q <= 1'b0;
    end else if (cmd_vld) begin
      armed_q <= (cmd_op == OP_RST_EN);
      st_q    <= S_IDLE;
      rpos_q  <= '0;
      got_q   <= 1'b0;
      rloop_q <= 1'b0;
      rlen_q  <= 2'd1;
      two_q   <= 1'b0;
      case (cmd_op)
        OP_WREN:   wren_q <= 1'b1;
        OP_WRDI:   wren_q <= 1'b0;
        OP_A4_ON:  a4_q   <= 1'b1;
        OP_A4_OFF: a4_q   <= 1'b0;
        OP_RST: begin
          if (armed_q) begin
            vc_q   <= vc_from(nv_q);
            ev_q   <= ev_from(nv_q);
            seg_q  <= seg_from(nv_q);
            a4_q   <= ~nv_q[0];
            wren_q <= 1'b0;
          end
        end
        OP_SEG_RD: begin
          st_q  <= S_READ;
          rb0_q <= seg_q;
        end
        OP_NV_RD: begin
          st_q   <= S_READ;
          rb0_q  <= nv_q[7:0];
          rb1_q  <= nv_q[15:8];
          rlen_q <= 2'd2;
        end
        OP_VC_RD: begin
          st_q  <= S_READ;
          rb0_q <= vc_q;
        end
        OP_EV_RD: begin
          st_q  <= S_READ;
          rb0_q <= ev_q;
        end
        OP_FLAG: begin
          st_q    <= S_READ;
          rb0_q   <= {1'b1, 6'b0, a4_q};
          rloop_q <= 1'b1;
        end
        OP_SEG_WR: if (wren_q) begin
          st_q  <= S_COLL;
          tgt_q <= T_SEG;
        end
        OP_NV_WR: if (wren_q) begin
          st_q  <= S_COLL;
          tgt_q <= T_NV;
          two_q <= 1'b1;
        end
        OP_VC_WR: if (wren_q) begin
          st_q  <= S_COLL;
          tgt_q <= T_VC;
        end
        OP_EV_WR: if (wren_q) begin
          st_q  <= S_COLL;
          tgt_q <= T_EV;
        end
        default: ;
      endcase
    end else if (cs_end) begin
      st_q   <= S_IDLE;
      rpos_q <= '0;
    end else if (st_q == S_COLL && wr_vld) begin
      if (two_q && !got_q) begin
        lo_q  <= wr_byte;
        got_q <= 1'b1;
      end else begin
        st_q <= S_IDLE;
        case (tgt_q)
          T_SEG: seg_q <= wr_byte;
          T_NV:  nv_q  <= {wr_byte, lo_q};
          T_VC:  vc_q  <= wr_byte;
          T_EV:  ev_q  <= wr_byte;
          default: ;
        endcase
      end
    end else if (st_q == S_READ && rd_req) begin
      if (rloop_q && (rpos_q + 2'd1 == rlen_q))
        rpos_q <= '0;
      else if (rpos_q < rlen_q)
        rpos_q <= rpos_q + 2'd1;
    end
  end

  assign rd_data    = (st_q == S_READ && rpos_q < rlen_q) ? ((rpos_q == 2'd0) ? rb0_q : rb1_q) : 8'h00;
  assign addr_4b    = a4_q;
  assign dummy_clks = vc_q[7:4];
  assign seg_addr   = seg_q;
  assign wren       = wren_q;

endmodule

// File: rtl/flash_cfg_regs_chk.sv
module flash_cfg_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_vld,
  input logic [7:0] cmd_op,
  input logic       addr_4b,
  input logic [3:0] dummy_clks,
  input logic [7:0] seg_addr,
  input logic       wren
);

  logic prev_arm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       prev_arm <= 1'b0;
    else if (cmd_vld) prev_arm <= (cmd_op == 8'h66);
  end

  a_r5_enter_4b: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld && cmd_op == 8'hB7 |=> addr_4b);

  a_r5_leave_4b: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld && cmd_op == 8'hE9 |=> !addr_4b);

  a_r10_unarmed_noop: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld && cmd_op == 8'h99 && !prev_arm |=>
      $stable(addr_4b) && $stable(dummy_clks) && $stable(seg_addr) && $stable(wren));

  a_r10_armed_clears_wren: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld && cmd_op == 8'h99 && prev_arm |=> !wren);

  a_r11_wren_set: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld && cmd_op == 8'h06 |=> wren);

  a_r11_wren_clear: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld && cmd_op == 8'h04 |=> !wren);

endmodule

bind flash_cfg_regs flash_cfg_regs_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_op(cmd_op),
  .addr_4b(addr_4b), .dummy_clks(dummy_clks), .seg_addr(seg_addr), .wren(wren)
);

// File: tb/flash_cfg_regs_tb_top.sv
`timescale 1ns/1ps
module flash_cfg_regs_tb_top;

  localparam logic [7:0] SEG_MAX = 8'd3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, cmd_vld, wr_vld, rd_req, cs_end;
  logic [7:0] cmd_op, wr_byte, rd_data, seg_addr;
  logic       addr_4b, wren;
  logic [3:0] dummy_clks;

  flash_cfg_regs dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_op(cmd_op),
    .wr_vld(wr_vld), .wr_byte(wr_byte), .rd_req(rd_req), .cs_end(cs_end),
    .rd_data(rd_data), .addr_4b(addr_4b), .dummy_clks(dummy_clks),
    .seg_addr(seg_addr), .wren(wren)
  );

  int n_chk = 0;
  int n_fail = 0;

  logic [15:0] m_nv;
  logic [7:0]  m_vc, m_ev, m_seg;
  logic        m_a4, m_wren, m_armed, m_acc;

  function automatic logic [7:0] f_vc(input logic [15:0] nv);
    logic [7:0] v;
    v = 8'h03;
    if (nv[11:9] != 3'b111) v[3] = 1'b1;
    v[7:4] = nv[15:12];
    return v;
  endfunction

  function automatic logic [7:0] f_ev(input logic [15:0] nv);
    logic [7:0] v;
    v = 8'h1F;
    if (nv[2]) v[6] = 1'b1;
    if (nv[3]) v[7] = 1'b1;
    return v;
  endfunction

  task automatic rebuild();
    m_vc  = f_vc(m_nv);
    m_ev  = f_ev(m_nv);
    m_a4  = (m_nv[0] == 1'b0);
    m_seg = (m_nv[1] == 1'b0) ? SEG_MAX : 8'h00;
  endtask

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic hw_reset();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    m_nv = 16'h8FFF;
    rebuild();
    m_wren = 1'b0;
    m_armed = 1'b0;
  endtask

  task automatic issue(input logic [7:0] op);
    cmd_vld = 1'b1;
    cmd_op  = op;
    @(negedge clk);
    cmd_vld = 1'b0;
    if (op == 8'h99 && m_armed) begin
      rebuild();
      m_wren = 1'b0;
    end
    m_armed = (op == 8'h66);
    case (op)
      8'h06: m_wren = 1'b1;
      8'h04: m_wren = 1'b0;
      8'hB7: m_a4 = 1'b1;
      8'hE9: m_a4 = 1'b0;
      default: ;
    endcase
    m_acc = m_wren;
  endtask

  task automatic wr(input logic [7:0] b);
    wr_vld  = 1'b1;
    wr_byte = b;
    @(negedge clk);
    wr_vld = 1'b0;
  endtask

  task automatic rd(output logic [7:0] v);
    v = rd_data;
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic endt();
    cs_end = 1'b1;
    @(negedge clk);
    cs_end = 1'b0;
  endtask

  task automatic simple(input logic [7:0] op);
    issue(op);
    endt();
  endtask

  task automatic do_write(input logic [7:0] op, input logic [7:0] b0, input logic [7:0] b1);
    logic acc;
    issue(op);
    acc = m_acc;
    wr(b0);
    if (op == 8'hB1) wr(b1);
    endt();
    if (acc) begin
      case (op)
        8'hC5: m_seg = b0;
        8'hB1: m_nv  = {b1, b0};
        8'h81: m_vc  = b0;
        8'h61: m_ev  = b0;
        default: ;
      endcase
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [7:0] op, input int i);
    case (op)
      8'hB5: return (i == 0) ? m_nv[7:0] : (i == 1) ? m_nv[15:8] : 8'h00;
      8'hC8: return (i == 0) ? m_seg : 8'h00;
      8'h85: return (i == 0) ? m_vc : 8'h00;
      8'h65: return (i == 0) ? m_ev : 8'h00;
      8'h70: return {1'b1, 6'b0, m_a4};
      default: return 8'h00;
    endcase
  endfunction

  task automatic do_read(input logic [7:0] op, input int n, input string tag);
    logic [7:0] v;
    issue(op);
    for (int i = 0; i < n; i++) begin
      rd(v);
      chk(tag, {8'h00, v}, {8'h00, exp_rd(op, i)});
    end
    endt();
  endtask

  task automatic check_outs(input string tag);
    chk({tag, " R5 addr_4b"}, {15'd0, addr_4b}, {15'd0, m_a4});
    chk({tag, " R2 dummy_clks"}, {12'd0, dummy_clks}, {12'd0, m_vc[7:4]});
    chk({tag, " R6 seg_addr"}, {8'd0, seg_addr}, {8'd0, m_seg});
    chk({tag, " R11 wren"}, {15'd0, wren}, {15'd0, m_wren});
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] ops [15];
    int seed;
    rst_n = 1'b1; cmd_vld = 0; cmd_op = 0; wr_vld = 0; wr_byte = 0; rd_req = 0; cs_end = 0;
    seed = $urandom(32'h5EED);
    @(negedge clk);
    hw_reset();

    // R1: reset state
    check_outs("R1 reset");
    chk("R1 wren after reset", {15'd0, wren}, 16'd0);
    chk("R1 dummy default", {12'd0, dummy_clks}, 16'd8);
    do_read(8'hB5, 2, "R1 nv default");
    do_read(8'h85, 1, "R2 vc default");
    do_read(8'h65, 1, "R3 ev default");
    chk("R1 vc value", {8'd0, m_vc}, 16'h0083);
    chk("R1 ev value", {8'd0, m_ev}, 16'h00DF);

    // R5 / R9
    simple(8'hB7);
    check_outs("R5 enter");
    do_read(8'h70, 3, "R9 flag 4b on");
    simple(8'hE9);
    check_outs("R5 leave");
    do_read(8'h70, 4, "R9 flag 4b off");

    // R6 gating, R11 read past end
    do_write(8'hC5, 8'h5A, 8'h00);
    do_read(8'hC8, 1, "R6 seg write ignored");
    check_outs("R6 ignored");
    simple(8'h06);
    do_write(8'hC5, 8'h5A, 8'h00);
    do_read(8'hC8, 3, "R6 R11 seg write and overrun");
    check_outs("R6 accepted");

    // R7 nv write
    do_write(8'hB1, 8'h34, 8'h4A);
    do_read(8'hB5, 3, "R7 nv readback");

    // R10: unarmed and disarmed resets do nothing
    simple(8'h99);
    check_outs("R10 unarmed");
    do_read(8'h85, 1, "R10 vc unchanged");
    simple(8'h66);
    do_read(8'h70, 1, "R10 intervening cmd");
    simple(8'h99);
    check_outs("R10 disarmed");

    // R10 armed reset: rebuild from 0x4A34
    simple(8'h66);
    simple(8'h99);
    chk("R2 vc rebuilt", {8'd0, m_vc}, 16'h004B);
    chk("R3 ev rebuilt", {8'd0, m_ev}, 16'h005F);
    check_outs("R4 R10 rebuilt");
    chk("R4 four-byte on", {15'd0, addr_4b}, 16'd1);
    chk("R4 seg top", {8'd0, seg_addr}, {8'd0, SEG_MAX});
    do_read(8'h85, 1, "R2 vc after soft reset");
    do_read(8'h65, 1, "R3 ev after soft reset");
    do_read(8'hB5, 2, "R7 nv kept across soft reset");

    // R8
    do_write(8'h81, 8'h27, 8'h00);
    check_outs("R8 vc write ignored");
    simple(8'h06);
    do_write(8'h81, 8'h27, 8'h00);
    check_outs("R8 vc write");
    do_write(8'h61, 8'h11, 8'h00);
    do_read(8'h65, 2, "R8 ev write");
    simple(8'h04);
    check_outs("R11 wren cleared");

    hw_reset();
    check_outs("R1 second reset");
    do_read(8'hB5, 2, "R1 nv restored");

    for (int it = 0; it < 600; it++) begin
      int k;
      logic [7:0] b0, b1;
      ops = '{8'h06, 8'h04, 8'hB7, 8'hE9, 8'h66, 8'h99, 8'hC5, 8'hB1,
              8'h81, 8'h61, 8'hC8, 8'hB5, 8'h85, 8'h65, 8'h70};
      k  = int'($urandom % 16);
      b0 = 8'($urandom);
      b1 = 8'($urandom);
      if (k == 15) begin
        simple(8'h66);
        simple(8'h99);
      end else if (k <= 5) begin
        simple(ops[k]);
      end else if (k <= 9) begin
        do_write(ops[k], b0, b1);
      end else begin
        do_read(ops[k], 1 + int'($urandom % 4), "R6 R7 R8 R9 R11 random read");
      end
      check_outs("R10 random");
    end

    summary();
    $finish;
  end

endmodule